// File: doc/BRIEF.md
# Half-Duplex Transmit Access Sequencer with Collision Backoff

This block decides when a half-duplex Ethernet MAC may put a frame onto a shared medium. The MAC raises a transmit request and holds it. The sequencer waits until the carrier-sense input shows the medium free, then raises transmit-enable for as long as the frame is being sent. If the collision-detect input fires during the transmission, the sequencer drops transmit-enable at once and drives the jam output for a fixed number of bit ticks. It then waits a random number of slot times before it tries the same frame again.

The random wait is drawn from a free-running linear feedback shift register. Its range doubles with each further collision on the frame, up to a cap. After too many collisions the frame is abandoned and an error pulse is raised. A successful frame ends with a done pulse. Both outcomes clear the per-frame collision count. The surrounding MAC serialises the bytes and produces the bit-time and slot-time tick strobes. The sequencer only orders the access attempts.

Top module: `csma_backoff_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `tx_en`, `jam`, `tx_done` and `excess_err` are all 0 in the following cycle.
- R2: `tx_en` never rises while carrier is sensed. With `tx_req` high and `carrier_sense` low at an edge, `tx_en` is 1 in the cycle after that edge.
- R3: While the frame is being sent, `tx_end` high at an edge (with no collision) drops `tx_en` and gives a `tx_done` pulse exactly one cycle long in the following cycle.
- R4: `collision` high at an edge while `tx_en` is 1 makes `tx_en` 0 and `jam` 1 in the next cycle. `tx_en` and `jam` are never 1 together.
- R5: `jam` stays high for exactly `JAM_BITS` `bit_tick` strobes (default 32).
- R6: The wait after the n-th collision on a frame is an integer number w of `slot_tick` strobes, with 0 ≤ w ≤ 2^min(n, `BACKOFF_CAP`) − 1 (default cap 10). With both ticks held high, the cycles from the fall of `jam` to the next rise of `tx_en` number w + 2 when the medium is idle.
- R7: When a backoff ends, the retry still defers: `tx_en` stays low while `carrier_sense` is high. It rises in the cycle after carrier drops.
- R8: The collision numbered `MAX_COLL` + 1 (default 17) ends the frame. `excess_err` pulses for one cycle right after that collision's jam, and no retry follows. `tx_done` and `excess_err` never pulse together.
- R9: The collision count is cleared when a frame finishes or is abandoned. The first collision of the next frame again waits 0 or 1 slot.
- R10: After `tx_done` or `excess_err`, a `tx_req` that stays high starts no new attempt. A new frame begins only after `tx_req` has been seen low.
- R11: `collision` while not transmitting has no effect. It raises no jam and does not advance the collision count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_req | input | 1 | Frame pending. Held high until done or error is seen. |
| carrier_sense | input | 1 | Medium busy |
| collision | input | 1 | Collision detected on the medium |
| tx_end | input | 1 | Last bit of the frame sent |
| bit_tick | input | 1 | One strobe per bit time |
| slot_tick | input | 1 | One strobe per slot time (512 bit times) |
| tx_en | output | 1 | Frame transmission allowed |
| jam | output | 1 | Send the jam pattern |
| tx_done | output | 1 | One-cycle pulse: frame sent |
| excess_err | output | 1 | One-cycle pulse: frame abandoned after too many collisions |

## Verification
The bench builds the block with its default parameters: a 32-bit jam, a 16-collision limit and a range cap of 10. It holds `bit_tick` and `slot_tick` high on every cycle, so one tick equals one clock. Each backoff can then be read directly from the gap between the fall of jam and the rise of transmit-enable. This keeps even the seventeen-collision abandon path, with waits of up to 1023 slots at the capped range, within a few thousand cycles. That in turn allows the capped range (collisions 11 and later), the error exit and the clearing of the count on the next frame all to be checked against the widest windows.

// File: rtl/csma_pkg.sv
// Shared definitions for the transmit access sequencer.
// Assumes: one-hot-free binary state encoding is acceptable.
package csma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DEFER   = 3'd1,
        ST_XMIT    = 3'd2,
        ST_JAM     = 3'd3,
        ST_BACKOFF = 3'd4,
        ST_HOLD    = 3'd5
    } tx_state_e;

endpackage

// File: rtl/csma_lfsr.sv
// Free-running Galois shift register used as the random source for backoff.
// Assumes: TAPS describes a maximal-length polynomial and SEED is nonzero.
module csma_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);

    logic [W-1:0] state_q;

    // advance one step every clock; reload seed on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (state_q[0]) begin
            state_q <= (state_q >> 1) ^ TAPS;
        end else begin
            state_q <= state_q >> 1;
        end
    end

    assign value = state_q;

endmodule

// File: rtl/csma_jam_timer.sv
// Counts bit ticks while the jam is active and flags the final one.
// Assumes: run stays high for the whole jam; counter restarts whenever run is low.
module csma_jam_timer #(
    parameter int JAM_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic bit_tick,
    output logic expire
);

    localparam int CNT_W = $clog2(JAM_BITS + 1);

    logic [CNT_W-1:0] count_q;

    // count bit ticks during jam, hold at zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            count_q <= '0;
        end else if (bit_tick) begin
            count_q <= count_q + 1'b1;
        end
    end

    // final tick of the jam window
    always_comb begin
        expire = run && bit_tick && (count_q == CNT_W'(JAM_BITS - 1));
    end

endmodule

// File: rtl/csma_backoff_timer.sv
// Loads a masked random slot count and counts it down on slot ticks.
// Assumes: coll_n holds the collision number (1..) at the load edge.
module csma_backoff_timer #(
    parameter int CAP    = 10,
    parameter int COLL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [COLL_W-1:0] coll_n,
    input  logic [CAP-1:0]    rnd,
    input  logic              run,
    input  logic              slot_tick,
    output logic              zero
);

    logic [CAP-1:0] mask;
    logic [CAP-1:0] remain_q;

    // range mask: bit i is open when the collision number exceeds i
    for (genvar i = 0; i < CAP; i++) begin : g_mask
        assign mask[i] = (coll_n > COLL_W'(i));
    end

    // load the draw, then step down once per slot while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= rnd & mask;
        end else if (run && slot_tick && (remain_q != '0)) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign zero = (remain_q == '0);

endmodule

// File: rtl/csma_backoff_ctrl.sv
// Sequences half-duplex transmit attempts: defer, send, jam, back off, retry.
// Assumes: tx_req is held until tx_done or excess_err, tx_end is a single
// strobe on the last bit, tick inputs are single-cycle strobes.
module csma_backoff_ctrl #(
    parameter int           MAX_COLL    = 16,
    parameter int           JAM_BITS    = 32,
    parameter int           BACKOFF_CAP = 10,
    parameter int           LFSR_W      = 16,
    parameter logic [15:0]  LFSR_TAPS   = 16'hB400,
    parameter logic [15:0]  LFSR_SEED   = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_req,
    input  logic carrier_sense,
    input  logic collision,
    input  logic tx_end,
    input  logic bit_tick,
    input  logic slot_tick,
    output logic tx_en,
    output logic jam,
    output logic tx_done,
    output logic excess_err
);

    import csma_pkg::*;

    localparam int COLL_W = $clog2(MAX_COLL + 2);

    tx_state_e         state_q, state_d;
    logic [COLL_W-1:0] coll_q;
    logic              done_q, err_q;
    logic              jam_expire, bo_zero, give_up;
    logic [LFSR_W-1:0] rnd;

    csma_lfsr #(
        .W    (LFSR_W),
        .TAPS (LFSR_W'(LFSR_TAPS)),
        .SEED (LFSR_W'(LFSR_SEED))
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    csma_jam_timer #(
        .JAM_BITS (JAM_BITS)
    ) u_jam (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q == ST_JAM),
        .bit_tick (bit_tick),
        .expire   (jam_expire)
    );

    csma_backoff_timer #(
        .CAP    (BACKOFF_CAP),
        .COLL_W (COLL_W)
    ) u_bo (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      ((state_q == ST_JAM) && jam_expire),
        .coll_n    (coll_q),
        .rnd       (rnd[BACKOFF_CAP-1:0]),
        .run       (state_q == ST_BACKOFF),
        .slot_tick (slot_tick),
        .zero      (bo_zero)
    );

    // the collision just jammed is one past the limit
    assign give_up = (coll_q > COLL_W'(MAX_COLL));

    // next-state selection for the access sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (tx_req) state_d = carrier_sense ? ST_DEFER : ST_XMIT;
            ST_DEFER:   if (!carrier_sense) state_d = ST_XMIT;
            ST_XMIT: begin
                if (collision)   state_d = ST_JAM;
                else if (tx_end) state_d = ST_HOLD;
            end
            ST_JAM:     if (jam_expire) state_d = give_up ? ST_HOLD : ST_BACKOFF;
            ST_BACKOFF: if (bo_zero) state_d = ST_DEFER;
            ST_HOLD:    if (!tx_req) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // per-frame collision count: bump on abort, clear on either outcome
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coll_q <= '0;
        end else if (state_q == ST_XMIT && collision) begin
            coll_q <= coll_q + 1'b1;
        end else if ((state_q == ST_XMIT && tx_end) ||
                     (state_q == ST_JAM && jam_expire && give_up)) begin
            coll_q <= '0;
        end
    end

    // one-cycle outcome pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= (state_q == ST_XMIT) && !collision && tx_end;
            err_q  <= (state_q == ST_JAM) && jam_expire && give_up;
        end
    end

    assign tx_en      = (state_q == ST_XMIT);
    assign jam        = (state_q == ST_JAM);
    assign tx_done    = done_q;
    assign excess_err = err_q;

endmodule

// File: rtl/csma_backoff_ctrl_checker.sv
// Temporal properties of the access sequencer, observed at its ports.
// Assumes: bound into every instance of csma_backoff_ctrl.
module csma_backoff_ctrl_checker #(
    parameter int JAM_BITS = 32
) (
    input logic clk,
    input logic rst_n,
    input logic carrier_sense,
    input logic collision,
    input logic tx_end,
    input logic bit_tick,
    input logic tx_en,
    input logic jam,
    input logic tx_done,
    input logic excess_err
);

    localparam int JT_W = $clog2(JAM_BITS + 1) + 1;

    logic [JT_W-1:0] jam_ticks;

    // bit ticks seen during the current or most recent jam
    always_ff @(posedge clk) begin
        if (!rst_n)              jam_ticks <= '0;
        else if (jam && bit_tick) jam_ticks <= jam_ticks + 1'b1;
        else if (!jam)            jam_ticks <= '0;
    end

    assert_no_send_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> !$past(carrier_sense));

    assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_en && jam));

    assert_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && collision) |=> (jam && !tx_en));

    assert_jam_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(jam) |-> (jam_ticks == JT_W'(JAM_BITS)));

    assert_done_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> $past(tx_en && tx_end));

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    assert_err_after_jam_R8: assert property (@(posedge clk) disable iff (!rst_n)
        excess_err |-> $past(jam));

    assert_no_dual_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_done && excess_err));

endmodule

bind csma_backoff_ctrl csma_backoff_ctrl_checker #(.JAM_BITS(JAM_BITS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .carrier_sense (carrier_sense),
    .collision     (collision),
    .tx_end        (tx_end),
    .bit_tick      (bit_tick),
    .tx_en         (tx_en),
    .jam           (jam),
    .tx_done       (tx_done),
    .excess_err    (excess_err)
);

// File: tb/csma_backoff_ctrl_test.sv
module csma_backoff_ctrl_test;

    localparam int MAX_COLL = 16;
    localparam int JAM_BITS = 32;
    localparam int CAP      = 10;

    logic clk = 1'b0;
    logic rst_n, tx_req, carrier_sense, collision, tx_end, bit_tick, slot_tick;
    logic tx_en, jam, tx_done, excess_err;

    int checks = 0;
    int failures = 0;
    int max_late_wait = 0;
    int exp_q[$];

    always #5 clk = ~clk;

    csma_backoff_ctrl uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_req        (tx_req),
        .carrier_sense (carrier_sense),
        .collision     (collision),
        .tx_end        (tx_end),
        .bit_tick      (bit_tick),
        .slot_tick     (slot_tick),
        .tx_en         (tx_en),
        .jam           (jam),
        .tx_done       (tx_done),
        .excess_err    (excess_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pop the expected outcome (1 done, 2 error) at each pulse
    always @(negedge clk) begin
        if (rst_n === 1'b1 && (tx_done || excess_err)) begin
            int got;
            got = tx_done ? 1 : 2;
            if (exp_q.size() == 0) begin
                check(1'b0, "R3/R8", "unexpected outcome pulse", got, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(got == e, "R3/R8", "outcome kind", got, e);
            end
        end
    end

    // one frame with ncoll forced collisions; range check tagged with tag
    task automatic run_frame(input int ncoll, input bit expect_err, input string tag);
        int t;
        exp_q.push_back(expect_err ? 2 : 1);
        tx_req = 1'b1;
        t = 0;
        while (!tx_en && t < 100) begin @(negedge clk); t++; end
        check(tx_en, "R2", "first attempt starts", tx_en, 1);
        for (int a = 1; a <= ncoll; a++) begin
            int jl, gap, w, lim;
            collision = 1'b1;
            @(negedge clk);
            collision = 1'b0;
            check(jam && !tx_en, "R4", "abort to jam", {jam, tx_en}, 2);
            jl = 0;
            while (jam && jl < 200) begin jl++; @(negedge clk); end
            check(jl == JAM_BITS, "R5", "jam length", jl, JAM_BITS);
            if (a > MAX_COLL) begin
                check(excess_err, "R8", "error after last jam", excess_err, 1);
            end else begin
                gap = 0;
                while (!tx_en && gap < 3000) begin gap++; @(negedge clk); end
                w = gap - 2;
                lim = (1 << ((a < CAP) ? a : CAP)) - 1;
                check(w >= 0 && w <= lim, tag, "backoff within range", w, lim);
                if (a >= 5 && w > max_late_wait) max_late_wait = w;
            end
        end
        if (!expect_err) begin
            tx_end = 1'b1;
            @(negedge clk);
            tx_end = 1'b0;
            check(tx_done && !tx_en, "R3", "done pulse, tx_en off", {tx_done, tx_en}, 2);
        end else begin
            int seen;
            seen = 0;
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                if (tx_en || jam) seen++;
            end
            check(seen == 0, "R8", "no retry after abandon", seen, 0);
        end
        tx_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int t;
        rst_n = 1'b0; tx_req = 1'b1; carrier_sense = 1'b0; collision = 1'b0;
        tx_end = 1'b0; bit_tick = 1'b1; slot_tick = 1'b1;
        repeat (4) @(negedge clk);
        check(!tx_en && !jam && !tx_done && !excess_err, "R1", "outputs in reset",
              {tx_en, jam, tx_done, excess_err}, 0);
        tx_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: defer while busy, start the cycle after carrier drops
        carrier_sense = 1'b1;
        tx_req = 1'b1;
        exp_q.push_back(1);
        t = 0;
        for (int k = 0; k < 12; k++) begin @(negedge clk); if (tx_en) t++; end
        check(t == 0, "R2", "no send while carrier", t, 0);
        carrier_sense = 1'b0;
        @(negedge clk);
        check(tx_en, "R2", "start after carrier drops", tx_en, 1);
        repeat (5) @(negedge clk);
        tx_end = 1'b1;
        @(negedge clk);
        tx_end = 1'b0;
        check(tx_done && !tx_en, "R3", "done after end strobe", {tx_done, tx_en}, 2);
        @(negedge clk);
        check(!tx_done, "R3", "done is one cycle", tx_done, 0);

        // R10: request held high after done starts nothing
        t = 0;
        for (int k = 0; k < 10; k++) begin @(negedge clk); if (tx_en) t++; end
        check(t == 0, "R10", "held request ignored", t, 0);
        tx_req = 1'b0;
        @(negedge clk);

        run_frame(0, 1'b0, "R6");
        run_frame(3, 1'b0, "R6");
        run_frame(10, 1'b0, "R6");
        run_frame(12, 1'b0, "R6");

        // R11: collision while idle is ignored
        collision = 1'b1;
        @(negedge clk);
        collision = 1'b0;
        t = 0;
        for (int k = 0; k < 5; k++) begin @(negedge clk); if (jam || tx_en) t++; end
        check(t == 0, "R11", "idle collision gives no jam", t, 0);
        run_frame(1, 1'b0, "R11");

        // R8: abandon after the limit, then R9: count cleared
        run_frame(MAX_COLL + 1, 1'b1, "R6");
        run_frame(1, 1'b0, "R9");

        // R7: retry defers to carrier after backoff
        exp_q.push_back(1);
        tx_req = 1'b1;
        while (!tx_en) @(negedge clk);
        collision = 1'b1;
        @(negedge clk);
        collision = 1'b0;
        while (jam) @(negedge clk);
        carrier_sense = 1'b1;
        t = 0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); if (tx_en) t++; end
        check(t == 0, "R7", "retry held by carrier", t, 0);
        carrier_sense = 1'b0;
        @(negedge clk);
        check(tx_en, "R7", "retry after carrier drops", tx_en, 1);
        tx_end = 1'b1;
        @(negedge clk);
        tx_end = 1'b0;
        tx_req = 1'b0;
        repeat (3) @(negedge clk);

        check(max_late_wait > 1, "R6", "wider range used after many collisions",
              max_late_wait, 2);
        check(exp_q.size() == 0, "R3/R8", "all outcomes seen", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule